// File: doc/BRIEF.md
# Dual-Bus Message Retry Sequencer

This block manages the retry policy for one message sent over a pair of redundant buses. A message begins with a start pulse. The pulse carries two retry allowances, the bus for the first attempt and a policy bit. The block holds all of these for the life of the message. The allowances come with each message; nothing is kept from one message to the next.

The protocol engine reports the result of every attempt with a done strobe and a pass/fail flag. The block then does one of three things: it announces success, it asks for another attempt and names the bus to use, or it gives up with a failure strobe.

There are two policies:
- **Sequential (policy bit 0):** all same-bus retries are spent first, then all alternate-bus retries.
- **Interleaved (policy bit 1):** the two allowances are pooled into one combined budget, and the bus flips on every retry.

Top module: `retry_sequencer`

## Requirements
- R1: After reset, `retry_req`, `seq_ok` and `seq_fail` are 0 and `retry_bus` is 0. The policy register inside the block resets to 0 (sequential).
- R2: One clock edge after `msg_start`, `retry_bus` equals `init_bus`. The two allowances and the policy bit are captured at that edge.
- R3: A passing attempt (`xfer_done`=1, `xfer_ok`=1) raises `seq_ok` in the following cycle. It does not raise `retry_req`, and the message is over.
- R4: With policy 0, the first `same_budget` retries use the original bus. The next `alt_budget` retries use the other bus.
- R5: With policy 0 and `same_budget`=0, the first retry already goes to the other bus.
- R6: With policy 1, every retry uses the bus opposite to the one used by the previous attempt.
- R7: With policy 1, exactly `same_budget`+`alt_budget` retries are granted before failure.
- R8: A failed attempt with no retries left raises `seq_fail` for one cycle in the following cycle. When both allowances are 0, this happens on the first failure.
- R9: `retry_bus` does not change between a retry request and the next `xfer_done`.
- R10: `retry_req` is a single-cycle pulse in the cycle after a failed attempt that still has budget. At most one of `retry_req`, `seq_ok` and `seq_fail` is high in any cycle.
- R11: `xfer_done` is ignored while no message is active: no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| msg_start | input | 1 | Begins a message and captures its settings |
| same_budget | input | CNT_W | Retries allowed on the original bus |
| alt_budget | input | CNT_W | Retries allowed on the other bus |
| init_bus | input | 1 | Bus for the first attempt (0 or 1) |
| interleave | input | 1 | Policy: 0 sequential, 1 interleaved |
| xfer_done | input | 1 | Attempt finished (one-cycle strobe) |
| xfer_ok | input | 1 | Attempt result, valid with `xfer_done` |
| retry_req | output | 1 | Request for another attempt |
| retry_bus | output | 1 | Bus for the current or requested attempt |
| seq_ok | output | 1 | Message succeeded (one cycle) |
| seq_fail | output | 1 | Message failed after all retries (one cycle) |

## Verification
The assertions rely on three properties of the inputs:
- `xfer_done` is a one-cycle strobe.
- `xfer_ok` is only meaningful while `xfer_done` is high.
- `msg_start` does not arrive in the same cycle as a `xfer_done` that it is meant to answer.

The stimulus respects all three. It pulses `xfer_done` for a single cycle with at least one idle cycle between attempts, and it issues `msg_start` only after the previous message has ended. The sweep covers:
- both policies and both starting buses;
- every pair of allowances from 0 to 5;
- every point at which the passing attempt can occur, including no pass at all.

// File: rtl/rtry_pkg.sv
package rtry_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_e;

  // Bus for a granted retry: flip each time when interleaved; otherwise
  // stay on the original bus while same-bus budget remains.
  function automatic logic pick_bus(input logic interleave, input logic cur,
                                    input logic orig, input logic from_same);
    if (interleave) return ~cur;
    return from_same ? orig : ~orig;
  endfunction
endpackage

// File: rtl/rtry_budget.sv
module rtry_budget #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] same_in,
  input  logic [CNT_W-1:0] alt_in,
  input  logic             interleave,
  input  logic             take,
  output logic             have_retry,
  output logic             from_same
);
  localparam int POOL_W = CNT_W + 1;

  logic [CNT_W-1:0]  same_left, alt_left;
  logic [POOL_W-1:0] pool;

  function automatic logic [POOL_W-1:0] pooled(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign from_same  = (same_left != '0);
  assign have_retry = interleave ? (pool != '0)
                                 : (from_same || (alt_left != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      same_left <= '0;
      alt_left  <= '0;
      pool      <= '0;
    end else if (load) begin
      same_left <= same_in;
      alt_left  <= alt_in;
      pool      <= pooled(same_in, alt_in);
    end else if (take && have_retry) begin
      if (interleave)     pool      <= pool - 1'b1;
      else if (from_same) same_left <= same_left - 1'b1;
      else                alt_left  <= alt_left - 1'b1;
    end
  end

  // R7
  pool_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && have_retry && interleave && !load) |=> (pool == $past(pool) - 1'b1));

  // R4
  same_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !interleave && !load && !from_same) |=> (same_left == '0));
endmodule

// File: rtl/rtry_bus.sv
module rtry_bus
  import rtry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic init_bus,
  input  logic interleave,
  input  logic take,
  input  logic from_same,
  output logic bus
);
  logic orig_q, bus_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orig_q <= 1'b0;
      bus_q  <= 1'b0;
    end else if (load) begin
      orig_q <= init_bus;
      bus_q  <= init_bus;
    end else if (take) begin
      bus_q  <= pick_bus(interleave, bus_q, orig_q, from_same);
    end
  end

  assign bus = bus_q;

  // R6
  flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && interleave && !load) |=> (bus_q != $past(bus_q)));
endmodule

// File: rtl/retry_sequencer.sv
module retry_sequencer
  import rtry_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic [CNT_W-1:0] same_budget,
  input  logic [CNT_W-1:0] alt_budget,
  input  logic             init_bus,
  input  logic             interleave,
  input  logic             xfer_done,
  input  logic             xfer_ok,
  output logic             retry_req,
  output logic             retry_bus,
  output logic             seq_ok,
  output logic             seq_fail
);
  seq_state_e state_q;
  logic mode_q;
  logic have_retry, from_same;

  // Named internal events
  logic busy, pass_evt, fail_evt, take_evt, giveup_evt;
  assign busy       = (state_q == ST_WAIT);
  assign pass_evt   = busy && xfer_done && xfer_ok && !msg_start;
  assign fail_evt   = busy && xfer_done && !xfer_ok && !msg_start;
  assign take_evt   = fail_evt && have_retry;
  assign giveup_evt = fail_evt && !have_retry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      retry_req <= 1'b0;
      seq_ok    <= 1'b0;
      seq_fail  <= 1'b0;
    end else begin
      retry_req <= take_evt;
      seq_ok    <= pass_evt;
      seq_fail  <= giveup_evt;
      if (msg_start) begin
        state_q <= ST_WAIT;
        mode_q  <= interleave;
      end else if (pass_evt || giveup_evt) begin
        state_q <= ST_IDLE;
      end
    end
  end

  rtry_budget #(.CNT_W(CNT_W)) u_budget (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (msg_start),
    .same_in    (same_budget),
    .alt_in     (alt_budget),
    .interleave (mode_q),
    .take       (take_evt),
    .have_retry (have_retry),
    .from_same  (from_same)
  );

  rtry_bus u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (msg_start),
    .init_bus   (init_bus),
    .interleave (mode_q),
    .take       (take_evt),
    .from_same  (from_same),
    .bus        (retry_bus)
  );

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_req, seq_ok, seq_fail}));

  // R3
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ok |-> $past(xfer_done && xfer_ok));

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |-> $past(xfer_done && !xfer_ok));

  // R10
  retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done && !msg_start) |=> $stable(retry_bus));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !msg_start) |=> !(retry_req || seq_ok || seq_fail));
endmodule

// File: tb/tb_retry_sequencer.sv
module tb_retry_sequencer;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic msg_start, init_bus, interleave, xfer_done, xfer_ok;
  logic [CNT_W-1:0] same_budget, alt_budget;
  logic retry_req, retry_bus, seq_ok, seq_fail;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  retry_sequencer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start),
    .same_budget(same_budget), .alt_budget(alt_budget),
    .init_bus(init_bus), .interleave(interleave),
    .xfer_done(xfer_done), .xfer_ok(xfer_ok),
    .retry_req(retry_req), .retry_bus(retry_bus),
    .seq_ok(seq_ok), .seq_fail(seq_fail));

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected bus for the k-th retry (k counts from 1)
  function automatic int exp_bus(input int md, input int ib, input int s, input int k);
    if (md == 1) return ib ^ (k % 2);
    return (k <= s) ? ib : 1 - ib;
  endfunction

  task automatic run_msg(input int md, input int ib, input int s, input int a, input int pass_at);
    int total, att, cur;
    bit fin;
    total = s + a;
    @(negedge clk);
    msg_start = 1; interleave = md[0]; init_bus = ib[0];
    same_budget = s[CNT_W-1:0]; alt_budget = a[CNT_W-1:0];
    @(negedge clk);
    msg_start = 0;
    chk(retry_bus == ib[0], "R2", int'(retry_bus), ib);
    cur = ib; att = 0; fin = 0;
    while (!fin) begin
      @(negedge clk);
      chk(retry_bus == cur[0], "R9", int'(retry_bus), cur);
      xfer_done = 1; xfer_ok = (att == pass_at);
      @(negedge clk);
      xfer_done = 0;
      if (att == pass_at) begin
        xfer_ok = 0;
        chk(seq_ok && !retry_req && !seq_fail, "R3", {seq_ok, retry_req, seq_fail}, 3'b100);
        fin = 1;
      end else if (att < total) begin
        chk(retry_req && !seq_ok && !seq_fail, "R10", {retry_req, seq_ok, seq_fail}, 3'b100);
        cur = exp_bus(md, ib, s, att + 1);
        if (md == 1)      chk(retry_bus == cur[0], "R6", int'(retry_bus), cur);
        else if (s == 0)  chk(retry_bus == cur[0], "R5", int'(retry_bus), cur);
        else              chk(retry_bus == cur[0], "R4", int'(retry_bus), cur);
        att++;
      end else begin
        if (md == 1) chk(seq_fail && !retry_req, "R7", {seq_fail, retry_req}, 2'b10);
        else         chk(seq_fail && !retry_req, "R8", {seq_fail, retry_req}, 2'b10);
        fin = 1;
      end
    end
    @(negedge clk);
    chk(!retry_req && !seq_ok && !seq_fail, "R10", {retry_req, seq_ok, seq_fail}, 0);
  endtask

  initial begin
    rst_n = 0; msg_start = 0; init_bus = 0; interleave = 0;
    xfer_done = 0; xfer_ok = 0; same_budget = '0; alt_budget = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!retry_req && !seq_ok && !seq_fail && !retry_bus, "R1",
        {retry_req, seq_ok, seq_fail, retry_bus}, 0);
    // R11: done strobes with no message active
    for (int ok = 0; ok < 2; ok++) begin
      xfer_done = 1; xfer_ok = ok[0];
      @(negedge clk);
      xfer_done = 0; xfer_ok = 0;
      chk(!retry_req && !seq_ok && !seq_fail, "R11", {retry_req, seq_ok, seq_fail}, 0);
      @(negedge clk);
    end
    // R8: both budgets zero, first failure ends the message
    run_msg(0, 1, 0, 0, 99);
    // Sweep: policy, start bus, budgets, point of success
    for (int md = 0; md < 2; md++)
      for (int ib = 0; ib < 2; ib++)
        for (int s = 0; s < 6; s++)
          for (int a = 0; a < 6; a++)
            for (int p = 0; p <= s + a + 1; p++)
              run_msg(md, ib, s, a, p);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule